// File: doc/BRIEF.md
# Storage Port Control and Status Register

This block is the control word of one storage host port. It sits on a simple 32-bit register bus with two write addresses. A write to the set address turns on every control bit written as 1. A write to the clear address turns off every control bit written as 1. Reading returns the live status word: the stored configuration bits, the state of the three handshake bits, and a ready flag.

Three handshakes run against a modelled link side. The first is the release of the held port reset. The second is a self-clearing device reset. The third is a self-clearing port initialize. Each one ends either when the link raises a one-cycle done pulse or when a parameterised cycle budget runs out, whichever happens first. Software starts a handshake, polls the status word until the bit it wrote reads low, and issues commands only while the ready flag reads 1.

A device reset that the link confirms with its done pulse leaves the port ready. A device reset that only times out does not, and software then runs an initialize, which always ends with ready set. The 12-byte or 16-byte command-packet choice is a plain configuration bit and is also brought out as a pin.

Top module: `port_ctrl_status`

## Requirements
- R1: After the active-low synchronous reset, the status word reads 0x00000001 (port reset held), ready is 0, and the link-busy output is 0.
- R2: A write to the set address (byte offset 0) sets each configuration bit written as 1 and leaves the rest unchanged. The configuration bits are 3, 5, 6, 10 and 13, so the configuration mask is 0x2468.
- R3: A write to the clear address (byte offset 4) clears each configuration bit written as 1 and leaves the rest unchanged.
- R4: Undefined bits always read 0. Bit 31 cannot be set or cleared by any write. Bits 1 and 2 ignore writes to the clear address. Writes to any other address change nothing.
- R5: Bit 0 stays 1 until software writes it as 1 to the clear address. It then keeps reading 1 and drops to 0 exactly RELEASE_CYCLES cycles after that write, or at the first earlier clock edge at which link done is sampled high. Ready stays 0 throughout.
- R6: Writing bit 0 to the set address takes effect from the next cycle in every state. Bit 0 reads 1, ready reads 0, and any running device reset or initialize is abandoned (bits 1 and 2 read 0).
- R7: Setting bit 1 while the port is idle and not in port reset makes bit 1 read 1 from the next cycle. Bit 1 then clears itself DEVRST_CYCLES cycles after the write, or at an earlier sampled link done. Ready becomes 1 at that moment only if the reset ended on link done.
- R8: Setting bit 2 while the port is idle and not in port reset makes bit 2 read 1. Bit 2 clears itself at the same edge at which ready becomes 1. That happens INIT_CYCLES cycles after the write, or earlier on a sampled link done.
- R9: Ready never reads 1 while any of bits 0, 1 or 2 reads 1. Ready is cleared in the cycle after a device reset or initialize is started.
- R10: Writing bit 1 or bit 2 to the set address while port reset is held or any handshake is running has no effect. If bits 1 and 2 are written together, only the device reset starts.
- R11: Bit 5 selects the command-packet length: 0 means 12 bytes and 1 means 16 bytes. The long-packet output equals bit 5.
- R12: A link done pulse while no handshake is running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrData | input | 32 | Write data |
| linkDone | input | 1 | One-cycle completion pulse from the link side |
| rdData | output | 32 | Live status word |
| portReady | output | 1 | Port may accept commands (same as status bit 31) |
| linkBusy | output | 1 | A release, device reset or initialize handshake is running |
| longPacketSel | output | 1 | 1 selects a 16-byte command packet, 0 selects 12 bytes |

## Verification
Every write acts on the rising edge at which it is sampled, so its effect on the status word is visible one cycle later. The bench drives a write, waits one rising edge, and samples on the following falling edge.

A handshake started at edge E ends at edge E+N, where N is the cycle budget. A link done pulse ends the handshake at the very edge at which it is sampled. The directed checks count exactly N-1 idle cycles, confirm that the bit is still high, and then confirm that it is low after one more cycle. Random traffic is compared on every cycle against a bench model that applies the same edge-by-edge rules.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int DATA_W = 32;

  // Status and control bit positions (software decodes these)
  localparam int BIT_PRST   = 0;
  localparam int BIT_DRST   = 1;
  localparam int BIT_INIT   = 2;
  localparam int BIT_WOC    = 3;
  localparam int BIT_PKT16  = 5;
  localparam int BIT_RESUME = 6;
  localparam int BIT_ACT32  = 10;
  localparam int BIT_PMEN   = 13;
  localparam int BIT_RDY    = 31;

  localparam logic [DATA_W-1:0] CFG_MASK =
      (32'h1 << BIT_WOC) | (32'h1 << BIT_PKT16) | (32'h1 << BIT_RESUME) |
      (32'h1 << BIT_ACT32) | (32'h1 << BIT_PMEN);

  localparam logic [DATA_W-1:0] DEFINED_MASK =
      CFG_MASK | (32'h1 << BIT_PRST) | (32'h1 << BIT_DRST) |
      (32'h1 << BIT_INIT) | (32'h1 << BIT_RDY);

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RELEASE = 2'd1,
    PH_DEVRST  = 2'd2,
    PH_INIT    = 2'd3
  } phase_e;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic prstOn;
    logic devOn;
    logic initOn;
    logic readyClr;
    logic readySet;
  } hs_strobe_t;
endpackage

// File: rtl/pcs_seq.sv
module pcs_seq
  import pcs_pkg::*;
#(
  parameter int RELEASE_CYCLES = 1250,
  parameter int DEVRST_CYCLES  = 12500,
  parameter int INIT_CYCLES    = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       setHit,
  input  logic       clrHit,
  input  logic [2:0] cmdBits,
  input  logic       linkDone,
  output hs_strobe_t hs,
  output logic       linkBusy
);
  localparam int MAX_A   = (RELEASE_CYCLES > DEVRST_CYCLES) ? RELEASE_CYCLES : DEVRST_CYCLES;
  localparam int MAX_LIM = (MAX_A > INIT_CYCLES) ? MAX_A : INIT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  phase_e            phase;
  logic              prstHeld;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limM1;
  logic              finish;
  logic              assertRst;
  logic              releaseReq;
  logic              canStart;
  logic              startDev;
  logic              startInit;

  always_comb begin
    case (phase)
      PH_RELEASE: limM1 = CNT_W'(RELEASE_CYCLES - 1);
      PH_DEVRST:  limM1 = CNT_W'(DEVRST_CYCLES - 1);
      PH_INIT:    limM1 = CNT_W'(INIT_CYCLES - 1);
      default:    limM1 = '0;
    endcase
  end

  assign finish     = (phase != PH_IDLE) && (linkDone || (cnt == limM1));
  assign assertRst  = setHit && cmdBits[BIT_PRST];
  assign releaseReq = clrHit && cmdBits[BIT_PRST] && prstHeld;
  assign canStart   = setHit && !cmdBits[BIT_PRST] && !prstHeld && (phase == PH_IDLE);
  assign startDev   = canStart && cmdBits[BIT_DRST];
  assign startInit  = canStart && !cmdBits[BIT_DRST] && cmdBits[BIT_INIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prstHeld <= 1'b1;
      phase    <= PH_IDLE;
      cnt      <= '0;
    end else if (assertRst) begin
      prstHeld <= 1'b1;
      phase    <= PH_IDLE;
      cnt      <= '0;
    end else if (releaseReq) begin
      prstHeld <= 1'b0;
      phase    <= PH_RELEASE;
      cnt      <= '0;
    end else if (finish) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
    end else if (phase != PH_IDLE) begin
      cnt      <= cnt + 1'b1;
    end else if (startDev) begin
      phase    <= PH_DEVRST;
    end else if (startInit) begin
      phase    <= PH_INIT;
    end
  end

  always_comb begin
    hs.prstOn   = prstHeld || (phase == PH_RELEASE);
    hs.devOn    = (phase == PH_DEVRST);
    hs.initOn   = (phase == PH_INIT);
    hs.readyClr = assertRst || startDev || startInit;
    hs.readySet = finish && ((phase == PH_INIT) || ((phase == PH_DEVRST) && linkDone));
  end

  assign linkBusy = (phase != PH_IDLE);
endmodule

// File: rtl/pcs_regs.sv
module pcs_regs
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setHit,
  input  logic              clrHit,
  input  logic [DATA_W-1:0] wrData,
  input  hs_strobe_t        hs,
  output logic [DATA_W-1:0] rdData,
  output logic              portReady,
  output logic              longPacketSel
);
  logic [DATA_W-1:0] cfgBits;
  logic              readyQ;
  logic [DATA_W-1:0] wrMasked;

  assign wrMasked = wrData & CFG_MASK;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBits <= '0;
    end else if (setHit) begin
      cfgBits <= cfgBits | wrMasked;
    end else if (clrHit) begin
      cfgBits <= cfgBits & ~wrMasked;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else if (hs.readyClr) begin
      readyQ <= 1'b0;
    end else if (hs.readySet) begin
      readyQ <= 1'b1;
    end
  end

  always_comb begin
    rdData           = cfgBits;
    rdData[BIT_PRST] = hs.prstOn;
    rdData[BIT_DRST] = hs.devOn;
    rdData[BIT_INIT] = hs.initOn;
    rdData[BIT_RDY]  = readyQ;
  end

  assign portReady     = readyQ;
  assign longPacketSel = cfgBits[BIT_PKT16];
endmodule

// File: rtl/port_ctrl_status.sv
module port_ctrl_status
  import pcs_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int SET_OFS        = 0,
  parameter int CLR_OFS        = 4,
  parameter int RELEASE_CYCLES = 1250,
  parameter int DEVRST_CYCLES  = 12500,
  parameter int INIT_CYCLES    = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              linkDone,
  output logic [31:0]       rdData,
  output logic              portReady,
  output logic              linkBusy,
  output logic              longPacketSel
);
  logic       setHit;
  logic       clrHit;
  hs_strobe_t hs;

  assign setHit = wrEn && (wrAddr == ADDR_W'(SET_OFS));
  assign clrHit = wrEn && (wrAddr == ADDR_W'(CLR_OFS));

  pcs_seq #(
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .DEVRST_CYCLES (DEVRST_CYCLES),
    .INIT_CYCLES   (INIT_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .setHit  (setHit),
    .clrHit  (clrHit),
    .cmdBits (wrData[2:0]),
    .linkDone(linkDone),
    .hs      (hs),
    .linkBusy(linkBusy)
  );

  pcs_regs u_regs (
    .clk          (clk),
    .rstN         (rstN),
    .setHit       (setHit),
    .clrHit       (clrHit),
    .wrData       (wrData),
    .hs           (hs),
    .rdData       (rdData),
    .portReady    (portReady),
    .longPacketSel(longPacketSel)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pcs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int SET_OFS = 0,
  parameter int CLR_OFS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrBit0,
  input logic              wrBit5,
  input logic [31:0]       rdData,
  input logic              portReady
);
  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    portReady |-> !(rdData[BIT_PRST] || rdData[BIT_DRST] || rdData[BIT_INIT]));

  assert_undef_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~DEFINED_MASK) == 32'h0);

  assert_single_hs_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(rdData[BIT_DRST] && rdData[BIT_INIT]));

  assert_prst_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(SET_OFS) && wrBit0) |=>
      (rdData[BIT_PRST] && !portReady && !rdData[BIT_DRST] && !rdData[BIT_INIT]));

  assert_clear_cfg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(CLR_OFS) && wrBit5) |=> !rdData[BIT_PKT16]);

  assert_ready_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portReady) |-> $past(rdData[BIT_DRST] || rdData[BIT_INIT]));
endmodule

bind port_ctrl_status pcs_checker #(
  .ADDR_W (ADDR_W),
  .SET_OFS(SET_OFS),
  .CLR_OFS(CLR_OFS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrBit0   (wrData[0]),
  .wrBit5   (wrData[5]),
  .rdData   (rdData),
  .portReady(portReady)
);

// File: tb/port_ctrl_status_test.sv
`timescale 1ns/1ps
module port_ctrl_status_test;
  localparam int AW  = 8;
  localparam int REL = 5;
  localparam int DEV = 8;
  localparam int INI = 12;
  localparam logic [31:0] MASK = 32'h0000_2468;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        linkDone = 1'b0;
  logic [31:0] rdData;
  logic        portReady;
  logic        linkBusy;
  logic        longPacketSel;

  int total = 0;
  int bad = 0;

  // bench model state
  int       mPh = 0;   // 0 idle, 1 release, 2 device reset, 3 initialize
  int       mCnt = 0;
  bit       mPrst = 1'b1;
  bit [31:0] mCfg = '0;
  bit       mRdy = 1'b0;

  always #4 clk = ~clk;

  port_ctrl_status #(
    .ADDR_W(AW), .SET_OFS(0), .CLR_OFS(4),
    .RELEASE_CYCLES(REL), .DEVRST_CYCLES(DEV), .INIT_CYCLES(INI)
  ) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .linkDone(linkDone), .rdData(rdData), .portReady(portReady),
    .linkBusy(linkBusy), .longPacketSel(longPacketSel)
  );

  function automatic int limFor(int ph);
    return (ph == 1) ? REL : (ph == 2) ? DEV : INI;
  endfunction

  function automatic logic [31:0] expWord();
    logic [31:0] w;
    w = mCfg;
    w[0] = mPrst || (mPh == 1);
    w[1] = (mPh == 2);
    w[2] = (mPh == 3);
    w[31] = mRdy;
    return w;
  endfunction

  task automatic modelStep(bit we, logic [AW-1:0] a, logic [31:0] d, bit ld);
    bit setW, clrW, fin, rdySet;
    setW = we && (a == 0);
    clrW = we && (a == 4);
    fin = (mPh != 0) && (ld || (mCnt == limFor(mPh) - 1));
    rdySet = fin && ((mPh == 3) || ((mPh == 2) && ld));
    if (setW && d[0]) begin
      mPrst = 1'b1; mPh = 0; mCnt = 0; mRdy = 1'b0;
    end else if (clrW && d[0] && mPrst) begin
      mPrst = 1'b0; mPh = 1; mCnt = 0;
    end else if (fin) begin
      mPh = 0; mCnt = 0;
      if (rdySet) mRdy = 1'b1;
    end else if (mPh != 0) begin
      mCnt++;
    end else if (setW && d[1] && !mPrst) begin
      mPh = 2; mRdy = 1'b0;
    end else if (setW && d[2] && !mPrst) begin
      mPh = 3; mRdy = 1'b0;
    end
    if (setW) mCfg = mCfg | (d & MASK);
    if (clrW) mCfg = mCfg & ~(d & MASK);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at falling edge, model at rising edge, sample at next falling edge
  task automatic cyc(bit we, logic [AW-1:0] a, logic [31:0] d, bit ld);
    wrEn = we; wrAddr = a; wrData = d; linkDone = ld;
    @(posedge clk);
    modelStep(we, a, d, ld);
    @(negedge clk);
    wrEn = 1'b0; linkDone = 1'b0;
    check("R9 model word", rdData, expWord());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    #1_600_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B_3C4D));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 reset word", rdData, 32'h0000_0001);
    check("R1 ready", {31'b0, portReady}, 32'h0);
    check("R1 busy", {31'b0, linkBusy}, 32'h0);

    // R10/R4: handshake and bit31 writes during held reset ignored
    cyc(1, 0, 32'h8000_0006, 0);
    check("R10 start during reset", rdData, 32'h0000_0001);

    // R5 release timing
    cyc(1, 4, 32'h1, 0);
    check("R5 release busy", {31'b0, linkBusy}, 32'h1);
    idle(REL - 1);
    check("R5 still high", rdData, 32'h0000_0001);
    idle(1);
    check("R5 released", rdData, 32'h0);

    // R7 device reset by timeout: no ready
    cyc(1, 0, 32'h2, 0);
    check("R7 dev start", rdData, 32'h2);
    idle(DEV - 1);
    check("R7 dev still high", rdData, 32'h2);
    idle(1);
    check("R7 dev timeout no ready", rdData, 32'h0);

    // R8 initialize by timeout
    cyc(1, 0, 32'h4, 0);
    check("R8 init start", rdData, 32'h4);
    idle(INI - 1);
    check("R8 init still high", rdData, 32'h4);
    idle(1);
    check("R8 init ready", rdData, 32'h8000_0000);
    check("R8 ready pin", {31'b0, portReady}, 32'h1);

    // R9 ready drops on start; R7 link done gives ready
    cyc(1, 0, 32'h2, 0);
    check("R9 ready cleared", {31'b0, portReady}, 32'h0);
    idle(2);
    cyc(0, 0, 0, 1);
    check("R7 dev by link", rdData, 32'h8000_0000);

    // R10 both bits: device reset only; init during dev ignored
    cyc(1, 0, 32'h6, 0);
    check("R10 both bits", rdData, 32'h2);
    cyc(1, 0, 32'h4, 0);
    check("R10 init while busy", rdData, 32'h2);
    cyc(1, 4, 32'h6, 0);
    check("R4 clear self bits", rdData, 32'h2);
    cyc(0, 0, 0, 1);
    check("R7 second link end", rdData, 32'h8000_0000);

    // R8 init ended early by link
    cyc(1, 0, 32'h4, 0);
    cyc(0, 0, 0, 1);
    check("R8 init by link", rdData, 32'h8000_0000);

    // R12 idle link done
    cyc(0, 0, 0, 1);
    check("R12 idle done", rdData, 32'h8000_0000);
    check("R12 busy", {31'b0, linkBusy}, 32'h0);

    // R2, R11 configuration set
    cyc(1, 0, 32'hFFFF_FFF8, 0);
    check("R2 cfg set", rdData, 32'h8000_2468);
    check("R11 long packet", {31'b0, longPacketSel}, 32'h1);

    // R3, R11 clear bit 5
    cyc(1, 4, 32'h20, 0);
    check("R3 cfg clear", rdData, 32'h8000_2448);
    check("R11 short packet", {31'b0, longPacketSel}, 32'h0);

    // R4 other address and unclearable bits
    cyc(1, 8, 32'hFFFF_FFFF, 0);
    check("R4 other addr", rdData, 32'h8000_2448);
    cyc(1, 4, 32'h8000_0000, 0);
    check("R4 bit31 clear", rdData, 32'h8000_2448);

    // R6 port reset aborts initialize
    cyc(1, 0, 32'h4, 0);
    idle(3);
    cyc(1, 0, 32'h1, 0);
    check("R6 abort init", rdData, 32'h0000_2449);
    check("R6 busy", {31'b0, linkBusy}, 32'h0);

    // random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] d;
      logic [AW-1:0] a;
      int sel;
      d = $urandom & 32'h8010_246E;
      if ($urandom % 10 == 0) d[0] = 1'b1;
      sel = $urandom % 3;
      a = (sel == 0) ? AW'(0) : (sel == 1) ? AW'(4) : AW'(8);
      cyc(($urandom % 3) == 0, a, d, ($urandom % 7) == 0);
      check("R9 random ready pin", {31'b0, portReady}, {31'b0, mRdy});
      check("R11 random packet pin", {31'b0, longPacketSel}, {31'b0, mCfg[5]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule